// File: doc/BRIEF.md
# Variable-Latency Memory Stage Serializer

This block is the memory-stage controller of a two-wide, in-order pipeline. Each cycle the execute stage may hand it a pair of instructions: lane 0 is the older and lane 1 the younger. Each lane carries a two-bit kind saying whether it touches memory and, if so, whether the cache access hits or misses. The cache lookup itself happens elsewhere; this block only receives the outcome as an input.

The stage owns one memory port. Only one access may use it at a time, and a hit holds it for fewer cycles than a miss. A countdown counter is loaded with the access latency and counts to zero. When both lanes of a pair need memory, the older one goes first and the younger one starts only after the older has finished. Instructions that do not touch memory spend a single cycle in the stage. Results leave toward writeback strictly in program order, so a younger instruction never overtakes an older one still waiting on memory. A ready output toward execute stays low while any lane of the current pair is still held.

Top module: `memstage_serializer`

## Requirements
- R1: After reset is released and the internal reset synchroniser has settled, `in_ready` is 1 and `wb_valid` is 0.
- R2: A captured non-memory lane (kind 2'b00) with no older lane still held appears on `wb_valid` in the first cycle after the capturing clock edge.
- R3: A memory access holds the port for HIT_LAT cycles on a hit (kind 2'b01) or MISS_LAT cycles on a miss (kind 2'b10). With the defaults 1 and 6, a lone lane-0 access appears on `wb_valid` in cycle 1 or cycle 6 after capture.
- R4: The port serves one access at a time, with lane 0 first. A lane-1 access behind a lane-0 access finishes in cycle L0+L1 after capture, where L0 and L1 are the two latencies.
- R5: Lanes leave in program order. A younger lane is never shown on `wb_valid` before the older lane, and a finished younger lane leaves in the same cycle as the older one.
- R6: `in_ready` is 1 exactly when no lane is held. A pair is captured only on an edge where `in_ready` is 1, and `in_valid` presented while `in_ready` is 0 has no effect on any output.
- R7: Each captured lane is shown on `wb_valid[i]` in exactly one cycle. In that cycle `wb_tag` bits [8*i+7:8*i] (TAG_W=8) carry the tag captured for that lane.
- R8: Kind 2'b11 is treated as a miss and uses MISS_LAT.
- R9: A lane whose `in_valid` bit is 0 at capture never appears on `wb_valid`, and it does not delay the other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | LANES | Per-lane instruction present from execute; bit 0 is the older lane |
| in_kind | input | 2*LANES | Per-lane kind at [2i+1:2i]: 00 no memory, 01 hit, 10 or 11 miss |
| in_tag | input | TAG_W*LANES | Per-lane instruction tag at [TAG_W*i +: TAG_W] |
| in_ready | output | 1 | Stage empty; a pair offered now is captured at the next edge |
| wb_valid | output | LANES | Per-lane "leaving toward writeback this cycle" |
| wb_tag | output | TAG_W*LANES | Tags of the held lanes, meaningful where wb_valid is set |

## Verification
The assertions take two things as given about the inputs. Execute changes its offer only between clock edges, and `in_kind` of an invalid lane is never looked at, so the counter always starts from a legal latency. The stimulus drives only from the falling edge. It sweeps every combination of valid pattern and kind for both lanes, back to back and with idle gaps. While `in_ready` is low it keeps offering a full pair of junk, so that an illegal capture shows up on the ports. It withdraws that junk in the same cycle that ready returns.

// File: rtl/msq_pkg.sv
package msq_pkg;

  // Lane kind encoding seen on in_kind
  typedef enum logic [1:0] {
    KIND_PLAIN    = 2'b00,
    KIND_HIT      = 2'b01,
    KIND_MISS     = 2'b10,
    KIND_MISS_ALT = 2'b11
  } lane_kind_e;

  function automatic logic kind_uses_port(input logic [1:0] k);
    return (k != KIND_PLAIN);
  endfunction

  function automatic logic kind_is_slow(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/msq_slot_bank.sv
module msq_slot_bank #(
  parameter int LANES = 2,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LANES-1:0]       ld_valid,
  input  logic [2*LANES-1:0]     ld_kind,
  input  logic [TAG_W*LANES-1:0] ld_tag,
  input  logic [LANES-1:0]       leave,
  input  logic [LANES-1:0]       done_now,
  output logic [LANES-1:0]       occ,
  output logic [LANES-1:0]       uses_port,
  output logic [LANES-1:0]       slow,
  output logic [LANES-1:0]       served,
  output logic [TAG_W*LANES-1:0] tag
);
  import msq_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic occ_q, occ_d, srv_q, srv_d, mem_q, slow_q;
    logic [TAG_W-1:0] tag_q;

    always_comb begin
      occ_d = occ_q;
      srv_d = srv_q;
      if (load) begin
        occ_d = ld_valid[g];
        srv_d = 1'b0;
      end else begin
        if (leave[g])    occ_d = 1'b0;
        if (done_now[g]) srv_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q <= 1'b0;
        srv_q <= 1'b0;
        mem_q <= 1'b0;
        slow_q <= 1'b0;
      end else begin
        occ_q <= occ_d;
        srv_q <= srv_d;
        if (load) begin
          mem_q  <= kind_uses_port(ld_kind[2*g +: 2]);
          slow_q <= kind_is_slow(ld_kind[2*g +: 2]);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (load) tag_q <= ld_tag[TAG_W*g +: TAG_W];
    end

    assign occ[g]                 = occ_q;
    assign served[g]              = srv_q;
    assign uses_port[g]           = mem_q;
    assign slow[g]                = slow_q;
    assign tag[TAG_W*g +: TAG_W]  = tag_q;

    // a lane that leaves must not have been a pending memory access
    AST_LEAVE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (leave[g] && mem_q) |-> (srv_q || done_now[g])); // R4
  end

endmodule

// File: rtl/msq_port_timer.sv
module msq_port_timer #(
  parameter int HIT_LAT  = 1,
  parameter int MISS_LAT = 6,
  parameter int IDX_W    = 1,
  localparam int CNT_W   = $clog2(MISS_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             start_slow,
  output logic             busy,
  output logic             fin,
  output logic [IDX_W-1:0] owner
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] own_q, own_d;

  assign fin   = busy_q && (cnt_q == '0);
  assign busy  = busy_q;
  assign owner = own_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    own_d  = own_q;
    if (start) begin
      busy_d = 1'b1;
      own_d  = start_idx;
      cnt_d  = start_slow ? CNT_W'(MISS_LAT - 1) : CNT_W'(HIT_LAT - 1);
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      own_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      own_q  <= own_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNT_W'(MISS_LAT - 1))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |-> !start); // R4

endmodule

// File: rtl/msq_retire.sv
module msq_retire #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] occ,
  input  logic [LANES-1:0] complete,
  output logic [LANES-1:0] leave
);

  always_comb begin
    logic older_clear;
    older_clear = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      leave[i]    = occ[i] && complete[i] && older_clear;
      older_clear = older_clear && (!occ[i] || leave[i]);
    end
  end

endmodule

// File: rtl/memstage_serializer.sv
module memstage_serializer #(
  parameter int LANES    = 2,
  parameter int TAG_W    = 8,
  parameter int HIT_LAT  = 1,
  parameter int MISS_LAT = 6,
  localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_valid,
  input  logic [2*LANES-1:0]     in_kind,
  input  logic [TAG_W*LANES-1:0] in_tag,
  output logic                   in_ready,
  output logic [LANES-1:0]       wb_valid,
  output logic [TAG_W*LANES-1:0] wb_tag
);
  import msq_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [LANES-1:0] occ, mem, slow, served, done_now, complete, leave, pend, in_mem;
  logic             capture, busy, fin, start, start_slow;
  logic [IDX_W-1:0] owner, start_idx;

  assign in_ready = rst_q && (occ == '0);
  assign capture  = in_ready && (in_valid != '0);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      in_mem[i]   = kind_uses_port(in_kind[2*i +: 2]);
      done_now[i] = fin && (owner == IDX_W'(i));
      complete[i] = occ[i] && (!mem[i] || served[i] || done_now[i]);
    end
  end

  // oldest lane still needing the port
  always_comb begin
    logic found;
    pend      = capture ? (in_valid & in_mem) : (occ & mem & ~served & ~done_now);
    found     = 1'b0;
    start_idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && !found) begin
        start_idx = IDX_W'(i);
        found     = 1'b1;
      end
    end
    start      = found && (!busy || fin);
    start_slow = capture ? kind_is_slow(in_kind[2*start_idx +: 2]) : slow[start_idx];
  end

  msq_slot_bank #(.LANES(LANES), .TAG_W(TAG_W)) u_slots (
    .clk(clk), .rst_n(rst_q), .load(capture),
    .ld_valid(in_valid), .ld_kind(in_kind), .ld_tag(in_tag),
    .leave(leave), .done_now(done_now),
    .occ(occ), .uses_port(mem), .slow(slow), .served(served), .tag(wb_tag)
  );

  msq_port_timer #(.HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_q), .start(start), .start_idx(start_idx),
    .start_slow(start_slow), .busy(busy), .fin(fin), .owner(owner)
  );

  msq_retire #(.LANES(LANES)) u_retire (
    .occ(occ), .complete(complete), .leave(leave)
  );

  assign wb_valid = leave;

  AST_OWNER_LIVE: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> (occ[owner] && mem[owner] && !served[owner])); // R4
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_q)
    (occ != '0) |=> (occ == ($past(occ) & ~$past(wb_valid)))); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    in_ready |-> (wb_valid == '0)); // R6
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_q)
    (wb_valid[LANES-1] && occ[0]) |-> wb_valid[0]); // R5

endmodule

// File: tb/memstage_serializer_test.sv
module memstage_serializer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  in_valid;
  logic [3:0]  in_kind;
  logic [15:0] in_tag;
  logic        in_ready;
  logic [1:0]  wb_valid;
  logic [15:0] wb_tag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memstage_serializer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_tag(in_tag), .in_ready(in_ready), .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [1:0] k);
    return k[1] ? 6 : 1;
  endfunction

  task automatic run_pair(input logic [1:0] v, input logic [1:0] ka,
                          input logic [1:0] kb, input logic [7:0] ta,
                          input logic [7:0] tb_);
    int pe, prev, kmax;
    int outc[2];
    logic [1:0] kk[2];
    logic [7:0] tt[2];
    string rq[2];
    kk[0] = ka; kk[1] = kb; tt[0] = ta; tt[1] = tb_;
    pe = 0; prev = 0; kmax = 1;
    for (int i = 0; i < 2; i++) begin
      outc[i] = 0;
      rq[i] = "R9";
      if (v[i]) begin
        int d;
        if (kk[i] == 2'b00) begin
          d = 1; rq[i] = "R2";
        end else begin
          pe += lat_of(kk[i]); d = pe;
          rq[i] = (kk[i] == 2'b11) ? "R8" : ((i == 1 && pe != d - 0 && 0) ? "R4" : "R3");
          if (i == 1 && v[0] && kk[0] != 2'b00) rq[i] = "R4";
        end
        if (d < prev) begin d = prev; rq[i] = "R5"; end
        outc[i] = d; prev = d;
        if (d > kmax) kmax = d;
      end
    end
    in_valid = v; in_kind = {kb, ka}; in_tag = {tb_, ta};
    @(negedge clk);
    for (int k = 1; k <= kmax + 1; k++) begin
      chk(in_ready == (k == kmax + 1), "R6", "in_ready", int'(in_ready), int'(k == kmax + 1));
      for (int i = 0; i < 2; i++) begin
        bit expv;
        expv = v[i] && (k == outc[i]);
        chk(wb_valid[i] == expv, rq[i], $sformatf("wb_valid lane %0d cycle %0d", i, k),
            int'(wb_valid[i]), int'(expv));
        if (expv)
          chk(wb_tag[8*i +: 8] == tt[i], "R7", $sformatf("wb_tag lane %0d", i),
              int'(wb_tag[8*i +: 8]), int'(tt[i]));
      end
      if (k <= kmax) begin
        in_valid = 2'b11; in_kind = ~{kb, ka}; in_tag = 16'hEEEE;
        @(negedge clk);
      end else begin
        in_valid = 2'b00;
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seq;
    rst_n = 1'b0; in_valid = '0; in_kind = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(wb_valid == 2'b00, "R1", "wb_valid after reset", int'(wb_valid), 0);
    seq = 0;
    for (int gap = 0; gap < 2; gap++) begin
      for (int v = 1; v <= 3; v++) begin
        for (int a = 0; a < 4; a++) begin
          for (int b = 0; b < 4; b++) begin
            if (gap == 1) begin
              @(negedge clk);
              chk(in_ready == 1'b1, "R6", "in_ready idle", int'(in_ready), 1);
              chk(wb_valid == 2'b00, "R6", "wb_valid idle", int'(wb_valid), 0);
            end
            run_pair(2'(v), 2'(a), 2'(b), 8'(2 * seq), 8'(2 * seq + 1));
            seq++;
          end
        end
      end
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule